// File: doc/BRIEF.md
# Prescaled Seconds Counter with Alarm

This block keeps time in whole seconds. A reloadable 20-bit down-counting divider turns the input clock into a one-cycle seconds tick. Each tick adds one to a 32-bit running count, which is compared against a 32-bit alarm value. Each tick sets a pending flag for the second event, and for the alarm match and count wrap when those happen. A summary flag is set for any of them. A 4-bit enable mask selects which pending flags drive the single interrupt line.

Software reaches the block over a 16-bit register bus with a 4-bit address. Writes take one cycle and reads are combinational. The wide values are split into high and low halves. The count, alarm and divider reload may only be changed in configuration mode. While that mode is set, the divider and count stand still, so a value written in two halves is never caught half-updated by a tick. A write-complete status bit drops for two cycles after every bus write.

Top module: `sec_alarm_timer`

## Requirements
- R1: After reset, the low control word (address 1) reads 0x0020: write-complete at bit 5 is high, and configuration mode (bit 4) and all pending flags (bits 3:0) are low. The count reads 0, the reload low half (address 3) reads 0x7FFF and the interrupt output is low.
- R2: Outside configuration mode, the divider counts down by one each cycle. In the cycle it holds 0, it issues a tick, reloads, and the count increments at that edge, so one tick arrives every reload+1 cycles. The divider halves read back at addresses 4 (high, 4 bits) and 5 (low).
- R3: Writes to the reload halves (addresses 2 and 3), count halves (6 high, 7 low) and alarm halves (8 high, 9 low) land only while configuration mode is set. Outside that mode such writes leave the register unchanged. The divider addresses ignore all writes.
- R4: While configuration mode (address 1, bit 4) is set, the divider and the count hold their values.
- R5: The alarm pending flag (bit 1) is set on the tick whose incremented count equals the alarm value, and on no other tick.
- R6: A tick taken when the count is all ones wraps it to 0 and sets the overflow pending flag (bit 2).
- R7: Every tick sets the second pending flag (bit 0). The global pending flag (bit 3) is set whenever any of bits 2:0 is set by an event.
- R8: A write to address 1 clears each pending flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1.
- R9: The interrupt output is high exactly when some pending flag is set and its enable is set. The enables sit at address 0, bits 3:0, in the same order as the flags.
- R10: After any bus write, write-complete (address 1, bit 5) reads 0 for the next two cycles and 1 in the third.
- R11: A write to either reload half also loads the divider with the new full reload value. The high reload half keeps only its 4 low data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the divider input |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | Write qualifier for busSel |
| busAddr | input | 4 | Register address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted divider state shows at the ports as a tick arriving at the wrong time. The count read after an exact window of free-running cycles is then off by one, and the divider read-back disagrees within a single period. A wrong count or alarm register shows as a missing or misplaced alarm or overflow flag on the tick itself, and the interrupt line follows in the same cycle when the flag is enabled. A stuck write-complete counter is visible on the status bit one cycle after any write.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int BUS_W    = 16;
  localparam int ADDR_W   = 4;
  localparam int PRE_W    = 20;
  localparam int CNT_W    = 32;
  localparam int PRE_HI_W = PRE_W - BUS_W;
  localparam int CNT_HI_W = CNT_W - BUS_W;
  localparam int NFLAG    = 4;
  localparam int WR_LAT   = 2;
  localparam int BUSY_W   = $clog2(WR_LAT + 1);

  // flag bit positions (shared by pending and enable words)
  localparam int FLG_SEC = 0;
  localparam int FLG_ALM = 1;
  localparam int FLG_OVF = 2;
  localparam int FLG_GLB = 3;
  localparam int CFG_BIT  = 4;
  localparam int DONE_BIT = 5;

  localparam logic [ADDR_W-1:0] A_CTRL_HI = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTRL_LO = 4'd1;
  localparam logic [ADDR_W-1:0] A_REL_HI  = 4'd2;
  localparam logic [ADDR_W-1:0] A_REL_LO  = 4'd3;
  localparam logic [ADDR_W-1:0] A_DIV_HI  = 4'd4;
  localparam logic [ADDR_W-1:0] A_DIV_LO  = 4'd5;
  localparam logic [ADDR_W-1:0] A_CNT_HI  = 4'd6;
  localparam logic [ADDR_W-1:0] A_CNT_LO  = 4'd7;
  localparam logic [ADDR_W-1:0] A_ALM_HI  = 4'd8;
  localparam logic [ADDR_W-1:0] A_ALM_LO  = 4'd9;

  typedef struct packed {
    logic relHi;
    logic relLo;
    logic cntHi;
    logic cntLo;
    logic almHi;
    logic almLo;
    logic flagWr;
  } strobe_t;
endpackage

// File: rtl/sat_datapath.sv
module sat_datapath
  import sat_pkg::*;
#(
  parameter logic [PRE_W-1:0] RELOAD_RST = 20'h07FFF
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [BUS_W-1:0] wdata,
  input  logic             cfgMode,
  output logic             tickEv,
  output logic [PRE_W-1:0] reloadVal,
  output logic [PRE_W-1:0] divVal,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] almVal,
  output logic [NFLAG-1:0] pendFlags
);
  logic [PRE_W-1:0] relNext;
  logic [CNT_W-1:0] cntNext, almNext, cntInc;
  logic [NFLAG-1:0] evt, keepMask;

  assign tickEv = !cfgMode && (divVal == '0);
  assign cntInc = cntVal + CNT_W'(1);

  always_comb begin
    relNext = reloadVal;
    if (stb.relHi) relNext[PRE_W-1:BUS_W] = wdata[PRE_HI_W-1:0];
    if (stb.relLo) relNext[BUS_W-1:0]     = wdata;
    cntNext = tickEv ? cntInc : cntVal;
    if (stb.cntHi) cntNext[CNT_W-1:BUS_W] = wdata[CNT_HI_W-1:0];
    if (stb.cntLo) cntNext[BUS_W-1:0]     = wdata;
    almNext = almVal;
    if (stb.almHi) almNext[CNT_W-1:BUS_W] = wdata[CNT_HI_W-1:0];
    if (stb.almLo) almNext[BUS_W-1:0]     = wdata;
  end

  always_comb begin
    evt = '0;
    evt[FLG_SEC] = tickEv;
    evt[FLG_ALM] = tickEv && (cntInc == almVal);
    evt[FLG_OVF] = tickEv && (cntVal == '1);
    evt[FLG_GLB] = evt[FLG_SEC] | evt[FLG_ALM] | evt[FLG_OVF];
    keepMask = stb.flagWr ? wdata[NFLAG-1:0] : '1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadVal <= RELOAD_RST;
      divVal    <= RELOAD_RST;
      cntVal    <= '0;
      almVal    <= '0;
      pendFlags <= '0;
    end else begin
      reloadVal <= relNext;
      if (stb.relHi || stb.relLo)
        divVal <= relNext;
      else if (!cfgMode)
        divVal <= (divVal == '0) ? reloadVal : divVal - PRE_W'(1);
      cntVal    <= cntNext;
      almVal    <= almNext;
      pendFlags <= (pendFlags & keepMask) | evt;
    end
  end
endmodule

// File: rtl/sat_ctrl.sv
module sat_ctrl
  import sat_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [CFG_BIT:0]   ctlWdata,
  input  logic [PRE_W-1:0]   reloadVal,
  input  logic [PRE_W-1:0]   divVal,
  input  logic [CNT_W-1:0]   cntVal,
  input  logic [CNT_W-1:0]   almVal,
  input  logic [NFLAG-1:0]   pendFlags,
  output strobe_t            stb,
  output logic               cfgMode,
  output logic [NFLAG-1:0]   enFlags,
  output logic               writeDone,
  output logic [BUS_W-1:0]   busRdata,
  output logic               irq
);
  logic wrEn, cfgWr;
  logic [BUSY_W-1:0] busyCnt;

  assign wrEn  = busSel && busWr;
  assign cfgWr = wrEn && cfgMode;

  always_comb begin
    stb        = '0;
    stb.relHi  = cfgWr && (busAddr == A_REL_HI);
    stb.relLo  = cfgWr && (busAddr == A_REL_LO);
    stb.cntHi  = cfgWr && (busAddr == A_CNT_HI);
    stb.cntLo  = cfgWr && (busAddr == A_CNT_LO);
    stb.almHi  = cfgWr && (busAddr == A_ALM_HI);
    stb.almLo  = cfgWr && (busAddr == A_ALM_LO);
    stb.flagWr = wrEn && (busAddr == A_CTRL_LO);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgMode <= 1'b0;
      enFlags <= '0;
      busyCnt <= '0;
    end else begin
      if (wrEn && busAddr == A_CTRL_HI) enFlags <= ctlWdata[NFLAG-1:0];
      if (stb.flagWr) cfgMode <= ctlWdata[CFG_BIT];
      if (wrEn)
        busyCnt <= BUSY_W'(WR_LAT);
      else if (busyCnt != '0)
        busyCnt <= busyCnt - BUSY_W'(1);
    end
  end

  assign writeDone = (busyCnt == '0);
  assign irq       = |(pendFlags & enFlags);

  always_comb begin
    busRdata = '0;
    case (busAddr)
      A_CTRL_HI: busRdata[NFLAG-1:0] = enFlags;
      A_CTRL_LO: begin
        busRdata[NFLAG-1:0] = pendFlags;
        busRdata[CFG_BIT]   = cfgMode;
        busRdata[DONE_BIT]  = writeDone;
      end
      A_REL_HI:  busRdata = BUS_W'(reloadVal[PRE_W-1:BUS_W]);
      A_REL_LO:  busRdata = reloadVal[BUS_W-1:0];
      A_DIV_HI:  busRdata = BUS_W'(divVal[PRE_W-1:BUS_W]);
      A_DIV_LO:  busRdata = divVal[BUS_W-1:0];
      A_CNT_HI:  busRdata = BUS_W'(cntVal[CNT_W-1:BUS_W]);
      A_CNT_LO:  busRdata = cntVal[BUS_W-1:0];
      A_ALM_HI:  busRdata = BUS_W'(almVal[CNT_W-1:BUS_W]);
      A_ALM_LO:  busRdata = almVal[BUS_W-1:0];
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/sec_alarm_timer.sv
module sec_alarm_timer
  import sat_pkg::*;
#(
  parameter logic [PRE_W-1:0] RELOAD_RST = 20'h07FFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic              irq
);
  strobe_t          stb;
  logic             cfgMode, tickEv, writeDone;
  logic [PRE_W-1:0] reloadVal, divVal;
  logic [CNT_W-1:0] cntVal, almVal;
  logic [NFLAG-1:0] pendFlags, enFlags;

  sat_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .ctlWdata(busWdata[CFG_BIT:0]),
    .reloadVal(reloadVal), .divVal(divVal), .cntVal(cntVal),
    .almVal(almVal), .pendFlags(pendFlags), .stb(stb),
    .cfgMode(cfgMode), .enFlags(enFlags), .writeDone(writeDone),
    .busRdata(busRdata), .irq(irq)
  );

  sat_datapath #(.RELOAD_RST(RELOAD_RST)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata),
    .cfgMode(cfgMode), .tickEv(tickEv), .reloadVal(reloadVal),
    .divVal(divVal), .cntVal(cntVal), .almVal(almVal),
    .pendFlags(pendFlags)
  );
endmodule

// File: rtl/sat_checker.sv
module sat_checker
  import sat_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             busSel,
  input logic             busWr,
  input logic             cfgMode,
  input logic             tickEv,
  input logic             writeDone,
  input logic             irq,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] almVal,
  input logic [NFLAG-1:0] pendFlags,
  input logic [NFLAG-1:0] enFlags
);
  // R10: a write pulls write-complete low on the next cycle
  a_r10_done_low: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr) |=> !writeDone);

  // R4: no count movement in configuration mode without a write
  a_r4_hold_count: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode && !(busSel && busWr)) |=> $stable(cntVal));

  // R2: each tick advances the count by one
  a_r2_tick_inc: assert property (@(posedge clk) disable iff (!rstN)
    tickEv |=> (cntVal == $past(cntVal) + CNT_W'(1)));

  // R6: wrap goes to zero and raises the overflow flag
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (tickEv && cntVal == '1) |=> (cntVal == '0 && pendFlags[FLG_OVF]));

  // R5: alarm match raises the alarm flag
  a_r5_alarm: assert property (@(posedge clk) disable iff (!rstN)
    (tickEv && (cntVal + CNT_W'(1)) == almVal) |=> pendFlags[FLG_ALM]);

  // R7: a tick raises second and global flags
  a_r7_sec_glb: assert property (@(posedge clk) disable iff (!rstN)
    tickEv |=> (pendFlags[FLG_SEC] && pendFlags[FLG_GLB]));

  // R9: no enable, no interrupt
  a_r9_masked: assert property (@(posedge clk) disable iff (!rstN)
    (enFlags == '0) |-> !irq);
endmodule

bind sec_alarm_timer sat_checker uChk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
  .cfgMode(cfgMode), .tickEv(tickEv), .writeDone(writeDone), .irq(irq),
  .cntVal(cntVal), .almVal(almVal), .pendFlags(pendFlags), .enFlags(enFlags)
);

// File: tb/sec_alarm_timer_test.sv
module sec_alarm_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sec_alarm_timer uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  // {addr, write data, expected read}
  localparam int NVEC = 9;
  localparam logic [35:0] VEC [NVEC] = '{
    {4'd2, 16'hFFFF, 16'h000F},
    {4'd3, 16'h1234, 16'h1234},
    {4'd6, 16'hA5A5, 16'hA5A5},
    {4'd7, 16'h5A5A, 16'h5A5A},
    {4'd8, 16'h0F0F, 16'h0F0F},
    {4'd9, 16'hF0F0, 16'hF0F0},
    {4'd0, 16'hFFF5, 16'h0005},
    {4'd5, 16'h9999, 16'h1234},
    {4'd4, 16'h0000, 16'h000F}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    #1;
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic finish;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish();
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(4'd1, v); check("R1 ctrl low", v, 16'h0020);
    rd(4'd7, v); check("R1 count low", v, 16'h0000);
    rd(4'd3, v); check("R1 reload low", v, 16'h7FFF);
    check("R1 irq", {15'd0, irq}, 16'h0000);

    // R3 alarm write outside configuration is dropped; R10 write-complete
    wr(4'd9, 16'h1111);
    #1; rd(4'd1, v); check("R10 done cycle 1", {15'd0, v[5]}, 16'h0000);
    rd(4'd9, v); check("R3 write ignored", v, 16'h0000);
    @(posedge clk); #2; rd(4'd1, v); check("R10 done cycle 2", {15'd0, v[5]}, 16'h0000);
    @(posedge clk); #2; rd(4'd1, v); check("R10 done cycle 3", {15'd0, v[5]}, 16'h0001);

    // table walk in configuration mode: R3 R11
    wr(4'd1, 16'h0010);
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][35:32], VEC[i][31:16]);
      rd(VEC[i][35:32], v);
      check($sformatf("R3 R11 table entry %0d", i), v, VEC[i][15:0]);
    end

    // setup: period 4, count 100, alarm 105, interrupts masked
    wr(4'd0, 16'h0000);
    wr(4'd2, 16'h0000);
    wr(4'd3, 16'h0003);
    rd(4'd5, v); check("R11 divider loaded", v, 16'h0003);
    wr(4'd6, 16'h0000);
    wr(4'd7, 16'd100);
    wr(4'd8, 16'h0000);
    wr(4'd9, 16'd105);

    // R4 hold in configuration mode
    repeat (20) @(posedge clk);
    #2;
    rd(4'd7, v); check("R4 count held", v, 16'd100);
    rd(4'd5, v); check("R4 divider held", v, 16'h0003);

    // run 40 cycles: 10 ticks (R2), alarm at 105 (R5), flags (R7)
    wr(4'd1, 16'h000F);
    repeat (39) @(posedge clk);
    wr(4'd1, 16'h001F);
    rd(4'd7, v); check("R2 count after 40 cycles", v, 16'd110);
    rd(4'd5, v); check("R2 divider after reload", v, 16'h0003);
    rd(4'd1, v); check("R5 R7 pending flags", {12'd0, v[3:0]}, 16'h000B);
    check("R9 masked irq", {15'd0, irq}, 16'h0000);

    // R9 enable alarm only
    wr(4'd0, 16'h0002);
    check("R9 irq enabled", {15'd0, irq}, 16'h0001);
    // R8 clear alarm flag only
    wr(4'd1, 16'h001D);
    rd(4'd1, v); check("R8 selective clear", {12'd0, v[3:0]}, 16'h0009);
    check("R9 irq after clear", {15'd0, irq}, 16'h0000);
    wr(4'd1, 16'h0010);
    wr(4'd0, 16'h0000);

    // R6 wrap: count all ones, one tick
    wr(4'd6, 16'hFFFF);
    wr(4'd7, 16'hFFFF);
    wr(4'd9, 16'h0007);
    wr(4'd1, 16'h0000);
    repeat (3) @(posedge clk);
    wr(4'd1, 16'h0010);
    rd(4'd6, v); check("R6 count high wrapped", v, 16'h0000);
    rd(4'd7, v); check("R6 count low wrapped", v, 16'h0000);
    rd(4'd1, v); check("R6 R7 flags, R5 no alarm", {12'd0, v[3:0]}, 16'h000D);

    // R8 writing ones leaves flags, zeros clear
    wr(4'd1, 16'h001F);
    rd(4'd1, v); check("R8 write ones no effect", {12'd0, v[3:0]}, 16'h000D);
    wr(4'd1, 16'h0010);
    rd(4'd1, v); check("R8 clear all", {12'd0, v[3:0]}, 16'h0000);

    // R2 running divider read-back after two free cycles
    wr(4'd1, 16'h0000);
    repeat (1) @(posedge clk);
    wr(4'd1, 16'h0010);
    rd(4'd5, v); check("R2 divider running", v, 16'h0001);

    // R11 reload write reloads divider
    wr(4'd3, 16'h0005);
    rd(4'd5, v); check("R11 divider reload", v, 16'h0005);

    finish();
  end
endmodule